// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block decides who owns a chip's external memory bus. Three masters compete for it: an outside device that asks for the bus with an active-low hold request, an on-chip DMA controller, and the CPU. The CPU owns the bus whenever nobody else asks. Ownership only changes on a clock edge where no bus access is in progress. When the outside device is given the bus, the block answers with an active-low hold acknowledge and disables every address, data and control driver so that the device can drive the pins itself.

The owning master issues single-cycle accesses through a simple handshake: it presents a valid pulse with address, write flag, byte enables, write data and a flag marking the target as internal memory or registers. One cycle later the pins show the access and a done flag is raised. An internal access does not disturb the external bus. The address and byte-high enable keep the values of the last external access, the strobes and chip selects stay inactive, and the data bus floats.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After reset the CPU grant is high, the DMA grant is low, hold acknowledge is high, the address and control output enables are high, the data output enable is low, all strobes, chip selects and byte-high enable are high, the address is zero and the address latch enable is low.
- R2: A low hold input is acted on only at an edge where no access is accepted and none is active; hold acknowledge falls in the cycle after the first such edge, never during an access.
- R3: Hold acknowledge stays low while the hold input stays low, and rises one cycle after the hold input goes high.
- R4: At each ownership decision the hold request wins over a DMA request, and a DMA request wins over the CPU; with no request the CPU is granted.
- R5: At most one of CPU grant, DMA grant and low hold acknowledge is active at any time, and grants do not change in the cycle after an access is accepted or while it is active.
- R6: While hold acknowledge is low, the address, data and control output enables are all low.
- R7: In the cycle hold acknowledge rises, all output enables are still low; they return high one cycle later when no new hold request is present.
- R8: An external access accepted in cycle t shows in cycle t+1: the address, address latch enable high, done high, read strobe low for a read, or write strobe low for a write with the low-byte strobe low when byte enable bit 0 is set and the high-byte strobe low when byte enable bit 1 is set, byte-high enable equal to the inverse of byte enable bit 1, and for writes the data output enable high with the write data; in cycle t+2 strobes and chip selects are high again, latch enable and data enable low, address unchanged.
- R9: An internal access accepted in cycle t shows in cycle t+1 with all strobes and chip selects high, the data output enable low, the address and byte-high enable unchanged from the last external access, address latch enable high and done high.
- R10: An access presented while the external master holds the bus, or in the release cycle, is ignored: no done, and the address and strobes are unchanged.
- R11: A DMA request raised during the hold state stays pending and is granted in the cycle after the release cycle.
- R12: During an external access, the chip select whose index equals the top two address bits (address bits 23:22 by default) is low and all others are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n_i | input | 1 | Active-low bus request from the outside master |
| hlda_n_o | output | 1 | Active-low hold acknowledge |
| dma_req_i | input | 1 | DMA bus request |
| dma_gnt_o | output | 1 | DMA bus grant |
| cpu_gnt_o | output | 1 | CPU bus grant |
| acc_valid_i | input | 1 | Access pulse from the granted master |
| acc_internal_i | input | 1 | Access targets internal memory or registers |
| acc_write_i | input | 1 | Access is a write |
| acc_be_i | input | DW/8 | Byte enables |
| acc_addr_i | input | AW | Access address |
| acc_wdata_i | input | DW | Write data |
| acc_done_o | output | 1 | Access shown on the bus this cycle |
| acc_rdata_o | output | DW | Read data from the data pins |
| ext_addr_o | output | AW | Address pins |
| ext_addr_oe_o | output | 1 | Address driver enable |
| ext_data_o | output | DW | Data pins, driven value |
| ext_data_i | input | DW | Data pins, received value |
| ext_data_oe_o | output | 1 | Data driver enable |
| ext_ctl_oe_o | output | 1 | Strobe, chip select and byte-high driver enable |
| ext_rd_n_o | output | 1 | Read strobe, active low |
| ext_wr_n_o | output | 1 | Write strobe, active low |
| ext_wrl_n_o | output | 1 | Low-byte write strobe, active low |
| ext_wrh_n_o | output | 1 | High-byte write strobe, active low |
| ext_bhe_n_o | output | 1 | Byte-high enable, active low |
| ext_cs_n_o | output | 2**CS_BITS | Chip selects, active low |
| ext_ale_o | output | 1 | Address latch enable |

## Verification
The two functions that can fall in the same cycle are a hold request and a bus access by the current owner, and a hold request and a DMA request at the same ownership decision. The bench lowers the hold input in the very cycle the CPU presents an access, with a DMA request raised during the hold, and judges that acknowledge stays high through the access and its active cycle, falls only after the first idle edge, and that the pending DMA request is granted only after the release cycle. It then raises hold and DMA requests together at an idle edge and expects the hold to win, and raises a DMA request beside a CPU access to confirm the CPU keeps the grant until the access has finished.

// File: rtl/bha_pkg.sv
package bha_pkg;

  // Bus owner encoding; OWN_GAP is the one-cycle turnaround after a hold
  typedef enum logic [1:0] {
    OWN_CPU = 2'd0,
    OWN_DMA = 2'd1,
    OWN_EXT = 2'd2,
    OWN_GAP = 2'd3
  } owner_e;

  // Fixed priority pick: outside master, then DMA, then CPU
  function automatic owner_e pick_owner(input logic hold_req, input logic dma_req);
    owner_e w;
    if (hold_req)      w = OWN_EXT;
    else if (dma_req)  w = OWN_DMA;
    else               w = OWN_CPU;
    return w;
  endfunction

endpackage

// File: rtl/bha_reset_sync.sv
module bha_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/bha_arbiter.sv
module bha_arbiter
  import bha_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic dma_req,
  input  logic acc_valid,
  input  logic acc_busy,
  output logic cpu_gnt,
  output logic dma_gnt,
  output logic hlda_n,
  output logic bus_en,
  output logic acc_take
);

  owner_e state_q, state_d;
  logic   idle;
  logic   state_en;

  // Next-state logic
  always_comb begin
    idle    = !acc_valid && !acc_busy;
    state_d = state_q;
    unique case (state_q)
      OWN_CPU, OWN_DMA: if (idle) state_d = pick_owner(hold_req, dma_req);
      OWN_EXT:          if (!hold_req) state_d = OWN_GAP;
      OWN_GAP:          state_d = pick_owner(hold_req, dma_req);
      default:          state_d = OWN_CPU;
    endcase
    state_en = (state_d != state_q);
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= OWN_CPU;
    else if (state_en) state_q <= state_d;
  end

  assign cpu_gnt  = (state_q == OWN_CPU);
  assign dma_gnt  = (state_q == OWN_DMA);
  assign hlda_n   = (state_q != OWN_EXT);
  assign bus_en   = cpu_gnt || dma_gnt;
  assign acc_take = acc_valid && bus_en;

  // R2
  hold_waits_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && (acc_valid || acc_busy)) |=> hlda_n);

  // R3
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hlda_n && hold_req) |=> !hlda_n);

  // R3
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hlda_n && !hold_req) |=> hlda_n);

  // R4
  prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !acc_valid && !acc_busy && hold_req) |=> !hlda_n);

  // R4
  prio_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !acc_valid && !acc_busy && !hold_req && dma_req) |=> dma_gnt);

  // R5
  grant_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_take || acc_busy) |=> ($stable(cpu_gnt) && $stable(dma_gnt)));

  // R7
  release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda_n) |-> !bus_en);

endmodule

// File: rtl/bha_cs_decode.sv
module bha_cs_decode #(
  parameter int AW      = 24,
  parameter int CS_BITS = 2,
  localparam int NCS    = 1 << CS_BITS
) (
  input  logic [AW-1:0]  addr,
  input  logic           en,
  output logic [NCS-1:0] cs_n
);

  logic [CS_BITS-1:0] sel;
  assign sel = addr[AW-1 -: CS_BITS];

  for (genvar k = 0; k < NCS; k++) begin : g_cs
    assign cs_n[k] = !(en && (sel == CS_BITS'(k)));
  end

endmodule

// File: rtl/bha_pin_drv.sv
module bha_pin_drv #(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int CS_BITS = 2,
  localparam int NBE    = DW / 8,
  localparam int NCS    = 1 << CS_BITS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic           acc_intl,
  input  logic           acc_write,
  input  logic [NBE-1:0] acc_be,
  input  logic [AW-1:0]  acc_addr,
  input  logic [DW-1:0]  acc_wdata,
  input  logic           bus_en,
  output logic [AW-1:0]  addr_o,
  output logic           addr_oe,
  output logic [DW-1:0]  data_o,
  output logic           data_oe,
  output logic           ctl_oe,
  output logic           rd_n,
  output logic           wr_n,
  output logic           wrl_n,
  output logic           wrh_n,
  output logic           bhe_n,
  output logic [NCS-1:0] cs_n,
  output logic           ale,
  output logic           busy
);

  logic           ext_take;
  logic           ext_wr;
  logic [NCS-1:0] cs_d;
  logic           rd_d, wr_d, wrl_d, wrh_d, doe_d, ale_d, busy_d;
  logic           addr_en, data_en;

  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q;
  logic           bhe_q, doe_q;
  logic           rd_q, wr_q, wrl_q, wrh_q, ale_q, busy_q;
  logic [NCS-1:0] cs_q;

  bha_cs_decode #(.AW(AW), .CS_BITS(CS_BITS)) u_cs (
    .addr (acc_addr),
    .en   (ext_take),
    .cs_n (cs_d)
  );

  // Next-state for the pin registers
  always_comb begin
    ext_take = take && !acc_intl;
    ext_wr   = ext_take && acc_write;
    busy_d   = take;
    ale_d    = take;
    rd_d     = !(ext_take && !acc_write);
    wr_d     = !ext_wr;
    wrl_d    = !(ext_wr && acc_be[0]);
    wrh_d    = !(ext_wr && acc_be[NBE-1]);
    doe_d    = ext_wr;
    addr_en  = ext_take;
    data_en  = ext_wr;
  end

  // Strobes and per-cycle controls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b1;
      wr_q   <= 1'b1;
      wrl_q  <= 1'b1;
      wrh_q  <= 1'b1;
      cs_q   <= '1;
      doe_q  <= 1'b0;
      ale_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      wrl_q  <= wrl_d;
      wrh_q  <= wrh_d;
      cs_q   <= cs_d;
      doe_q  <= doe_d;
      ale_q  <= ale_d;
      busy_q <= busy_d;
    end
  end

  // Address and byte-high enable keep the last external access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bhe_q  <= 1'b1;
    end else if (addr_en) begin
      addr_q <= acc_addr;
      bhe_q  <= !acc_be[NBE-1];
    end
  end

  // Write data register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= acc_wdata;
  end

  assign addr_o  = addr_q;
  assign data_o  = data_q;
  assign bhe_n   = bhe_q;
  assign rd_n    = rd_q;
  assign wr_n    = wr_q;
  assign wrl_n   = wrl_q;
  assign wrh_n   = wrh_q;
  assign cs_n    = cs_q;
  assign ale     = ale_q;
  assign busy    = busy_q;
  assign addr_oe = bus_en;
  assign ctl_oe  = bus_en;
  assign data_oe = doe_q && bus_en;

  // R8
  ext_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !acc_intl) |=> (ale && busy && (rd_n != wr_n)));

  // R8
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (rd_n && wr_n && wrl_n && wrh_n && (&cs_n) && !ale && !data_oe));

  // R9
  intl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && acc_intl) |=> ($stable(addr_o) && $stable(bhe_n) && rd_n && wr_n &&
                            wrl_n && wrh_n && (&cs_n) && !data_oe && ale));

  // R12
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !acc_intl) |=> ($countones(~cs_n) == 1));

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int CS_BITS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hold_n_i,
  output logic                     hlda_n_o,
  input  logic                     dma_req_i,
  output logic                     dma_gnt_o,
  output logic                     cpu_gnt_o,
  input  logic                     acc_valid_i,
  input  logic                     acc_internal_i,
  input  logic                     acc_write_i,
  input  logic [DW/8-1:0]          acc_be_i,
  input  logic [AW-1:0]            acc_addr_i,
  input  logic [DW-1:0]            acc_wdata_i,
  output logic                     acc_done_o,
  output logic [DW-1:0]            acc_rdata_o,
  output logic [AW-1:0]            ext_addr_o,
  output logic                     ext_addr_oe_o,
  output logic [DW-1:0]            ext_data_o,
  input  logic [DW-1:0]            ext_data_i,
  output logic                     ext_data_oe_o,
  output logic                     ext_ctl_oe_o,
  output logic                     ext_rd_n_o,
  output logic                     ext_wr_n_o,
  output logic                     ext_wrl_n_o,
  output logic                     ext_wrh_n_o,
  output logic                     ext_bhe_n_o,
  output logic [(1<<CS_BITS)-1:0]  ext_cs_n_o,
  output logic                     ext_ale_o
);

  logic rst_sn;
  logic bus_en, acc_take, acc_busy;

  bha_reset_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sn)
  );

  bha_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_sn),
    .hold_req  (!hold_n_i),
    .dma_req   (dma_req_i),
    .acc_valid (acc_valid_i),
    .acc_busy  (acc_busy),
    .cpu_gnt   (cpu_gnt_o),
    .dma_gnt   (dma_gnt_o),
    .hlda_n    (hlda_n_o),
    .bus_en    (bus_en),
    .acc_take  (acc_take)
  );

  bha_pin_drv #(.AW(AW), .DW(DW), .CS_BITS(CS_BITS)) u_pins (
    .clk       (clk),
    .rst_n     (rst_sn),
    .take      (acc_take),
    .acc_intl  (acc_internal_i),
    .acc_write (acc_write_i),
    .acc_be    (acc_be_i),
    .acc_addr  (acc_addr_i),
    .acc_wdata (acc_wdata_i),
    .bus_en    (bus_en),
    .addr_o    (ext_addr_o),
    .addr_oe   (ext_addr_oe_o),
    .data_o    (ext_data_o),
    .data_oe   (ext_data_oe_o),
    .ctl_oe    (ext_ctl_oe_o),
    .rd_n      (ext_rd_n_o),
    .wr_n      (ext_wr_n_o),
    .wrl_n     (ext_wrl_n_o),
    .wrh_n     (ext_wrh_n_o),
    .bhe_n     (ext_bhe_n_o),
    .cs_n      (ext_cs_n_o),
    .ale       (ext_ale_o),
    .busy      (acc_busy)
  );

  assign acc_done_o  = acc_busy;
  assign acc_rdata_o = ext_data_i;

  // R6
  hold_float_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !hlda_n_o |-> !(ext_addr_oe_o || ext_ctl_oe_o || ext_data_oe_o));

  // R7
  drivers_back_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ($rose(hlda_n_o) && hold_n_i) |=> (ext_addr_oe_o && ext_ctl_oe_o));

  // R10
  hold_ignores_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!hlda_n_o && acc_valid_i) |=> (!acc_done_o && $stable(ext_addr_o) && ext_wr_n_o));

  // R5
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({cpu_gnt_o, dma_gnt_o, !hlda_n_o}));

endmodule

// File: tb/bus_hold_arbiter_test.sv
module bus_hold_arbiter_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hold_n, dma_req;
  logic          acc_valid, acc_intl, acc_wr;
  logic [1:0]    acc_be;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_wdata;
  logic [DW-1:0] pin_din;
  logic          hlda_n, dma_gnt, cpu_gnt, done;
  logic [DW-1:0] rdata, data_o;
  logic [AW-1:0] addr_o;
  logic          addr_oe, data_oe, ctl_oe, rd_n, wr_n, wrl_n, wrh_n, bhe_n, ale;
  logic [3:0]    cs_n;

  int checks = 0;
  int errors = 0;
  int overlap = 0;
  bit wd_fired = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_arbiter uut (
    .clk(clk), .rst_n(rst_n), .hold_n_i(hold_n), .hlda_n_o(hlda_n),
    .dma_req_i(dma_req), .dma_gnt_o(dma_gnt), .cpu_gnt_o(cpu_gnt),
    .acc_valid_i(acc_valid), .acc_internal_i(acc_intl), .acc_write_i(acc_wr),
    .acc_be_i(acc_be), .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata),
    .acc_done_o(done), .acc_rdata_o(rdata), .ext_addr_o(addr_o),
    .ext_addr_oe_o(addr_oe), .ext_data_o(data_o), .ext_data_i(pin_din),
    .ext_data_oe_o(data_oe), .ext_ctl_oe_o(ctl_oe), .ext_rd_n_o(rd_n),
    .ext_wr_n_o(wr_n), .ext_wrl_n_o(wrl_n), .ext_wrh_n_o(wrh_n),
    .ext_bhe_n_o(bhe_n), .ext_cs_n_o(cs_n), .ext_ale_o(ale)
  );

  typedef struct packed {
    logic          intl;
    logic          wr;
    logic [1:0]    be;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic [AW-1:0] xaddr;
    logic          xrd, xwr, xwrl, xwrh, xbhe;
    logic [3:0]    xcs;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b0, 1'b0, 2'b11, 24'h012340, 16'h0000, 24'h012340, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'b1110},
    '{1'b0, 1'b1, 2'b01, 24'h400010, 16'hA5A5, 24'h400010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1101},
    '{1'b1, 1'b0, 2'b11, 24'h000400, 16'h0000, 24'h400010, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1111},
    '{1'b0, 1'b1, 2'b10, 24'h800002, 16'h1234, 24'h800002, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'b1011},
    '{1'b1, 1'b1, 2'b11, 24'h000800, 16'h7777, 24'h800002, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'b1111},
    '{1'b0, 1'b1, 2'b11, 24'hC0FFFE, 16'hBEEF, 24'hC0FFFE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0111},
    '{1'b0, 1'b0, 2'b01, 24'h000100, 16'h0000, 24'h000100, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1110},
    '{1'b1, 1'b1, 2'b10, 24'h000002, 16'h5555, 24'h000100, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1111}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_acc(input logic intl, input logic wr, input logic [1:0] be,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
    acc_valid = 1'b1; acc_intl = intl; acc_wr = wr; acc_be = be;
    acc_addr = a; acc_wdata = d;
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  // R5: no two owners at once, watched every cycle after reset
  always @(negedge clk)
    if (rst_n && (int'(cpu_gnt) + int'(dma_gnt) + int'(!hlda_n)) > 1) overlap++;

  task automatic run_all;
    rst_n = 1'b0; hold_n = 1'b1; dma_req = 1'b0; acc_valid = 1'b0;
    acc_intl = 1'b0; acc_wr = 1'b0; acc_be = 2'b00; acc_addr = '0;
    acc_wdata = '0; pin_din = 16'h3C3C;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1 grants/ack", {cpu_gnt, dma_gnt, hlda_n}, 3'b101);
    chk("R1 enables", {addr_oe, ctl_oe, data_oe}, 3'b110);
    chk("R1 strobes", {rd_n, wr_n, wrl_n, wrh_n, bhe_n, cs_n, ale, done}, {5'b11111, 4'b1111, 2'b00});
    chk("R1 address", addr_o, 24'h0);
    chk("R1 read data path", rdata, 16'h3C3C);

    // Vector walk: R8 external, R9 internal, R12 chip select
    for (int i = 0; i < 8; i++) begin
      drive_acc(VECS[i].intl, VECS[i].wr, VECS[i].be, VECS[i].addr, VECS[i].wd);
      step();
      chk(VECS[i].intl ? "R9 internal pins" : "R8/R12 external pins",
          {addr_o, rd_n, wr_n, wrl_n, wrh_n, bhe_n, cs_n, data_oe, ale, done},
          {VECS[i].xaddr, VECS[i].xrd, VECS[i].xwr, VECS[i].xwrl, VECS[i].xwrh,
           VECS[i].xbhe, VECS[i].xcs, VECS[i].wr & !VECS[i].intl, 1'b1, 1'b1});
      if (VECS[i].wr && !VECS[i].intl) chk("R8 write data", data_o, VECS[i].wd);
      acc_valid = 1'b0;
      step();
      chk("R8 idle after access",
          {addr_o, rd_n, wr_n, wrl_n, wrh_n, cs_n, data_oe, ale, done},
          {VECS[i].xaddr, 4'b1111, 4'b1111, 3'b000});
    end

    // R2: hold arrives together with a CPU access
    drive_acc(1'b0, 1'b0, 2'b11, 24'h000200, 16'h0);
    hold_n = 1'b0;
    step();
    chk("R2 ack high during access", {hlda_n, done, cpu_gnt}, 3'b111);
    acc_valid = 1'b0;
    step();
    chk("R2 ack high on active edge", {hlda_n, cpu_gnt}, 2'b11);
    step();
    chk("R2 ack low after idle edge", {hlda_n, cpu_gnt, dma_gnt}, 3'b000);
    chk("R6 drivers off", {addr_oe, ctl_oe, data_oe}, 3'b000);

    // R10 and R11: access ignored, DMA request pending
    dma_req = 1'b1;
    drive_acc(1'b0, 1'b1, 2'b11, 24'h400AAA, 16'h9999);
    step();
    chk("R10 access ignored in hold", {done, wr_n, addr_o}, {1'b0, 1'b1, 24'h000200});
    acc_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R3 ack held", {hlda_n, dma_gnt}, 2'b00);
    end
    hold_n = 1'b1;
    drive_acc(1'b0, 1'b1, 2'b11, 24'h400BBB, 16'h8888);
    step();
    chk("R7 release cycle", {hlda_n, addr_oe, ctl_oe, dma_gnt}, 4'b1000);
    step();
    chk("R10 access ignored in release", {done, wr_n, addr_o}, {1'b0, 1'b1, 24'h000200});
    acc_valid = 1'b0;
    chk("R11 pending DMA granted", {addr_oe, ctl_oe, dma_gnt, cpu_gnt}, 4'b1110);

    // DMA performs an external write
    drive_acc(1'b0, 1'b1, 2'b01, 24'h40_0040, 16'h0F0F);
    step();
    chk("R8 DMA write", {wr_n, wrl_n, wrh_n, bhe_n, cs_n, data_oe, data_o},
        {4'b0011, 4'b1101, 1'b1, 16'h0F0F});
    acc_valid = 1'b0;
    step();

    // R4: hold and DMA together at an idle edge
    hold_n = 1'b0;
    step();
    chk("R4 hold beats DMA", {hlda_n, dma_gnt, cpu_gnt}, 3'b000);
    dma_req = 1'b0; hold_n = 1'b1;
    step();
    step();
    chk("R4 CPU by default", {cpu_gnt, dma_gnt, hlda_n, addr_oe}, 4'b1011);

    // R5: DMA request beside a CPU access
    drive_acc(1'b1, 1'b0, 2'b11, 24'h000010, 16'h0);
    dma_req = 1'b1;
    step();
    chk("R5 CPU kept during access", {cpu_gnt, dma_gnt}, 2'b10);
    acc_valid = 1'b0;
    step();
    chk("R5 CPU kept on active edge", {cpu_gnt, dma_gnt}, 2'b10);
    step();
    chk("R4 DMA over CPU", {cpu_gnt, dma_gnt}, 2'b01);
    dma_req = 1'b0;
    step();
    chk("R4 back to CPU", {cpu_gnt, dma_gnt}, 2'b10);

    chk("R5 no overlapping owners", overlap, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        wd_fired = 1'b1;
      end
    join_any
    disable fork;
    if (wd_fired) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule